// File: doc/BRIEF.md
# Quad DAC Serial Command Controller

This block is the digital control core of a four-channel voltage-output DAC. A host sends 24-bit frames over a serial port (clock, active-low select, data in). Each frame carries a 4-bit operation code, a 4-bit channel selector and a 16-bit data word. The controller decodes the frame and updates a double-buffered register pair in every channel: a staging (input) register and the live register whose code drives the converter. It also keeps a power-down flag per channel and an enable flag for the on-chip reference.

The serial pins are oversampled by the system clock. A frame takes effect only when the select line rises after exactly 24 data bits. The resolution is a parameter, 12 or 16 bits. A strap input chooses the value that both registers of every channel take on reset: zero-scale or mid-scale. The analog conversion and the reference circuit sit outside this block.

Top module: `qdac_cmd_ctrl`

## Requirements
- R1: A frame is shifted in on rising `spi_sck` while `spi_cs_n` is low, MSB first. Bits 23:20 hold the operation, bits 19:16 the channel selector and bits 15:0 the data. The frame is executed when `spi_cs_n` rises.
- R2: A frame with any bit count other than 24 at the rise of `spi_cs_n` (for example 23 or 25) is discarded and changes no state.
- R3: Selector codes 0, 1, 2 and 3 pick channels A, B, C and D, and code 15 picks all four. The live code of channel n appears on `dac_code_o[n*RES +: RES]`.
- R4: Operation 0000 loads the data into the staging register of the selected channel(s). Their live registers and power flags are unchanged.
- R5: Operation 0001 copies the staging register into the live register of the selected channel(s) and clears their power-down flags.
- R6: Operation 0010 loads the staging register of the selected channel(s). It then copies staging to live in all four channels, using the new value where one was just loaded, and clears all four power-down flags.
- R7: Operation 0011 loads both the staging and the live register of the selected channel(s) with the data and clears their power-down flags.
- R8: Operation 0100 sets the power-down flag (`pd_o` bit n = 1) of the selected channel(s). Operation 0101 sets all four flags and clears `ref_en_o`.
- R9: Operation 0110 sets `ref_en_o` to 1 and operation 0111 clears it.
- R10: Operation 1111 does nothing. Any operation code not listed, and any selector other than 0 to 3 or 15, voids the whole frame, including chip-wide operations. No state changes.
- R11: While `rst_n` is low at a clock edge, every staging and live register takes zero if `reset_mid` is 0, and the MSB alone set (mid-scale) if `reset_mid` is 1. All `pd_o` bits are cleared and `ref_en_o` is set.
- R12: With RES = 12 the code is taken from data bits 15:4 (left-justified), and data bits 3:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_mid | input | 1 | Reset-value strap: 0 zero-scale, 1 mid-scale |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| dac_code_o | output | 4*RES | Live codes, channel n at bits n*RES +: RES |
| pd_o | output | 4 | Power-down flag per channel, 1 = powered down |
| ref_en_o | output | 1 | Internal reference enable |

## Verification
The bench covers the following corner cases:
- Write-then-update-all (0010): the channel just loaded must move its new data into the live register, not its stale staging value. A design that reads staging before the write would show the old code on that channel.
- Short and long frames (23 and 25 bits): these must leave every output untouched. A counter that only checks "at least 24" would apply the 25-bit frame.
- Illegal selector with a chip-wide operation: this checks that the selector voids the frame even when the operation ignores channels. A design that decodes the two separately would switch the reference.
- Nonzero low data nibble at 12 bits, plus both reset strap values: these expose a wrong slice or a swapped mid/zero choice as a wrong code on the outputs.

// File: rtl/qdac_pkg.sv
// Package: shared constants and types for the quad DAC command controller.
// Assumes a fixed four-channel device and a 24-bit frame layout.
package qdac_pkg;
    localparam int FRAME_BITS = 24;
    localparam int WORD_BITS  = 16;
    localparam int CHANNELS   = 4;
    localparam logic [3:0] SEL_ALL = 4'hF;

    typedef enum logic [3:0] {
        OP_LOAD        = 4'h0,
        OP_COMMIT      = 4'h1,
        OP_LOAD_ALLGO  = 4'h2,
        OP_LOAD_COMMIT = 4'h3,
        OP_SLEEP       = 4'h4,
        OP_SLEEP_CHIP  = 4'h5,
        OP_REF_ON      = 4'h6,
        OP_REF_OFF     = 4'h7,
        OP_IDLE        = 4'hF
    } op_e;

    typedef struct packed {
        logic [3:0]           op;
        logic [3:0]           sel;
        logic [WORD_BITS-1:0] data;
    } frame_t;
endpackage

// File: rtl/qdac_spi_rx.sv
// Module: serial frame receiver. Oversamples SCK, CS_N and MOSI with
// two-flop synchronisers, shifts on SCK rising while selected, and
// emits a one-cycle frame_vld_o on CS_N rising when exactly
// FRAME_BITS bits arrived. Assumes SCK is slower than clk/4.
module qdac_spi_rx
    import qdac_pkg::*;
#(
    parameter int NBITS = FRAME_BITS
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sck,
    input  logic   cs_n,
    input  logic   mosi,
    output logic   frame_vld_o,
    output frame_t frame_o
);
    localparam int CW  = $clog2(NBITS + 2);
    localparam int SAT = NBITS + 1;

    logic [2:0]       sck_q;
    logic [2:0]       cs_q;
    logic [1:0]       mosi_q;
    logic [NBITS-1:0] shreg;
    logic [CW-1:0]    bit_cnt;
    logic             sck_rise;
    logic             cs_rise;
    logic             selected;

    assign sck_rise = sck_q[1] & ~sck_q[2];
    assign cs_rise  = cs_q[1] & ~cs_q[2];
    assign selected = ~cs_q[1];

    // Synchronise the serial pins and keep one extra stage for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[1:0], sck};
            cs_q   <= {cs_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    // Shift data MSB first and count bits, saturating past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (!selected) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[NBITS-2:0], mosi_q[1]};
            if (bit_cnt != CW'(SAT)) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Release a frame only on deselect after an exact bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_vld_o <= 1'b0;
            frame_o     <= '0;
        end else begin
            frame_vld_o <= cs_rise && (bit_cnt == CW'(NBITS));
            if (cs_rise) begin
                frame_o <= frame_t'(shreg);
            end
        end
    end
endmodule

// File: rtl/qdac_decode.sv
// Module: operation decoder. Turns a valid frame into per-channel
// load, commit and sleep strobes plus reference on/off strobes.
// An unknown operation or selector voids the whole frame.
module qdac_decode
    import qdac_pkg::*;
#(
    parameter int NCH = CHANNELS
) (
    input  logic           frame_vld,
    input  frame_t         frame,
    output logic [NCH-1:0] load_o,
    output logic [NCH-1:0] commit_o,
    output logic [NCH-1:0] sleep_o,
    output logic           ref_on_o,
    output logic           ref_off_o
);
    logic [NCH-1:0] hit;
    logic sel_ok, known;
    logic f_load, f_commit, f_commit_all, f_sleep, f_sleep_all, f_ref_on, f_ref_off;
    logic go;

    // Map the selector to a channel mask.
    for (genvar g = 0; g < NCH; g++) begin : g_hit
        assign hit[g] = (frame.sel == SEL_ALL) || (frame.sel == 4'(g));
    end
    assign sel_ok = (frame.sel == SEL_ALL) || (frame.sel < 4'(NCH));

    // Classify the operation code into action flags.
    always_comb begin
        known = 1'b1;
        f_load = 1'b0; f_commit = 1'b0; f_commit_all = 1'b0;
        f_sleep = 1'b0; f_sleep_all = 1'b0; f_ref_on = 1'b0; f_ref_off = 1'b0;
        case (frame.op)
            OP_LOAD:        f_load = 1'b1;
            OP_COMMIT:      f_commit = 1'b1;
            OP_LOAD_ALLGO:  begin f_load = 1'b1; f_commit_all = 1'b1; end
            OP_LOAD_COMMIT: begin f_load = 1'b1; f_commit = 1'b1; end
            OP_SLEEP:       f_sleep = 1'b1;
            OP_SLEEP_CHIP:  begin f_sleep_all = 1'b1; f_ref_off = 1'b1; end
            OP_REF_ON:      f_ref_on = 1'b1;
            OP_REF_OFF:     f_ref_off = 1'b1;
            OP_IDLE:        known = 1'b1;
            default:        known = 1'b0;
        endcase
    end

    assign go = frame_vld && sel_ok && known;

    // Gate the flags into per-channel strobes.
    for (genvar g = 0; g < NCH; g++) begin : g_strobe
        assign load_o[g]   = go && f_load && hit[g];
        assign commit_o[g] = go && (f_commit_all || (f_commit && hit[g]));
        assign sleep_o[g]  = go && (f_sleep_all || (f_sleep && hit[g]));
    end
    assign ref_on_o  = go && f_ref_on;
    assign ref_off_o = go && f_ref_off;
endmodule

// File: rtl/qdac_chan.sv
// Module: one channel's staging/live register pair and power flag.
// A commit copies the post-load staging value and wakes the channel;
// commit wins over sleep. Reset value chosen by reset_mid.
module qdac_chan #(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reset_mid,
    input  logic           load,
    input  logic           commit,
    input  logic           sleep,
    input  logic [RES-1:0] data,
    output logic [RES-1:0] code_o,
    output logic           pd_o
);
    localparam logic [RES-1:0] MID = {1'b1, {(RES-1){1'b0}}};

    logic [RES-1:0] stage_q;
    logic [RES-1:0] stage_nxt;

    assign stage_nxt = load ? data : stage_q;

    // Hold staging and live codes; live follows staging on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= reset_mid ? MID : '0;
            code_o  <= reset_mid ? MID : '0;
        end else begin
            stage_q <= stage_nxt;
            if (commit) begin
                code_o <= stage_nxt;
            end
        end
    end

    // Track power-down: commit wakes, sleep powers down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_o <= 1'b0;
        end else if (commit) begin
            pd_o <= 1'b0;
        end else if (sleep) begin
            pd_o <= 1'b1;
        end
    end
endmodule

// File: rtl/qdac_cmd_ctrl.sv
// Module: top of the quad DAC command controller. Receives serial
// frames, decodes them and drives four channel register pairs and the
// reference enable. RES is 12 or 16; data is taken left-justified.
module qdac_cmd_ctrl
    import qdac_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reset_mid,
    input  logic                  spi_sck,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic [CHANNELS*RES-1:0] dac_code_o,
    output logic [CHANNELS-1:0]   pd_o,
    output logic                  ref_en_o
);
    logic                frm_vld;
    frame_t              frm;
    logic [CHANNELS-1:0] load, commit, sleep;
    logic                ref_on, ref_off;
    logic [RES-1:0]      code_word;

    assign code_word = frm.data[WORD_BITS-1 -: RES];

    qdac_spi_rx #(.NBITS(FRAME_BITS)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck         (spi_sck),
        .cs_n        (spi_cs_n),
        .mosi        (spi_mosi),
        .frame_vld_o (frm_vld),
        .frame_o     (frm)
    );

    qdac_decode #(.NCH(CHANNELS)) u_dec (
        .frame_vld (frm_vld),
        .frame     (frm),
        .load_o    (load),
        .commit_o  (commit),
        .sleep_o   (sleep),
        .ref_on_o  (ref_on),
        .ref_off_o (ref_off)
    );

    for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
        qdac_chan #(.RES(RES)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .reset_mid (reset_mid),
            .load      (load[g]),
            .commit    (commit[g]),
            .sleep     (sleep[g]),
            .data      (code_word),
            .code_o    (dac_code_o[g*RES +: RES]),
            .pd_o      (pd_o[g])
        );
    end

    // Reference enable: on by default, switched by command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_en_o <= 1'b1;
        end else if (ref_on) begin
            ref_en_o <= 1'b1;
        end else if (ref_off) begin
            ref_en_o <= 1'b0;
        end
    end
endmodule

// File: rtl/qdac_cmd_ctrl_chk.sv
// Module: assertion checker bound to qdac_cmd_ctrl. Relates decoded
// frames to the output state one cycle later.
module qdac_cmd_ctrl_chk
    import qdac_pkg::*;
#(
    parameter int RES = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frm_vld,
    input frame_t                  frm,
    input logic [CHANNELS*RES-1:0] dac_code_o,
    input logic [CHANNELS-1:0]     pd_o,
    input logic                    ref_en_o
);
    logic sel_ok, op_known;
    assign sel_ok   = (frm.sel == SEL_ALL) || (frm.sel < 4'(CHANNELS));
    assign op_known = (frm.op <= 4'h7) || (frm.op == 4'hF);

    // R1: a frame strobe lasts one cycle.
    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> !frm_vld);

    // R2: outputs only move on an executed frame.
    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> ($stable(dac_code_o) && $stable(pd_o) && $stable(ref_en_o)));

    // R10: void or idle frames change nothing.
    a_r10_void_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && (!sel_ok || !op_known || frm.op == 4'hF))
        |=> ($stable(dac_code_o) && $stable(pd_o) && $stable(ref_en_o)));

    // R8: chip sleep powers down all channels and the reference.
    a_r8_chip_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && sel_ok && frm.op == 4'h5) |=> (pd_o == '1 && !ref_en_o));

    // R9: reference-on command sets the enable.
    a_r9_ref_on: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && sel_ok && frm.op == 4'h6) |=> ref_en_o);

    // R6: load-and-commit-all wakes every channel.
    a_r6_wake_all: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && sel_ok && frm.op == 4'h2) |=> (pd_o == '0));

    // R7: broadcast load-and-commit sets every live code to the data.
    a_r7_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm.sel == SEL_ALL && frm.op == 4'h3)
        |=> (dac_code_o == {CHANNELS{$past(frm.data[WORD_BITS-1 -: RES])}} && pd_o == '0));
endmodule

bind qdac_cmd_ctrl qdac_cmd_ctrl_chk #(.RES(RES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_vld    (frm_vld),
    .frm        (frm),
    .dac_code_o (dac_code_o),
    .pd_o       (pd_o),
    .ref_en_o   (ref_en_o)
);

// File: tb/qdac_cmd_ctrl_bench.sv
// Bench: scoreboard. The driver sends frames, updates a behavioural
// model and pushes expected output items; the monitor pops and compares.
module qdac_cmd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RES = 12;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_mid = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic [NCH*RES-1:0] dac_code_o;
    logic [NCH-1:0] pd_o;
    logic ref_en_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_cmd_ctrl #(.RES(RES)) u_qdac_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .reset_mid(reset_mid),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .dac_code_o(dac_code_o), .pd_o(pd_o), .ref_en_o(ref_en_o));

    typedef struct {
        logic [NCH*RES-1:0] code;
        logic [NCH-1:0]     pd;
        logic               ref_en;
        string              tag;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [RES-1:0] m_stage [NCH];
    logic [RES-1:0] m_live  [NCH];
    logic [NCH-1:0] m_pd;
    logic           m_ref;

    function automatic void model_reset(bit mid);
        for (int i = 0; i < NCH; i++) begin
            m_stage[i] = mid ? {1'b1, {(RES-1){1'b0}}} : '0;
            m_live[i]  = m_stage[i];
        end
        m_pd = '0;
        m_ref = 1'b1;
    endfunction

    function automatic void model_apply(logic [3:0] op, logic [3:0] sel, logic [15:0] data);
        logic [NCH-1:0] hit;
        logic [RES-1:0] w;
        w = data[15 -: RES];
        if (sel == 4'hF) hit = '1;
        else if (sel < NCH) hit = NCH'(1) << sel;
        else return;
        case (op)
            4'h0: for (int i = 0; i < NCH; i++) if (hit[i]) m_stage[i] = w;
            4'h1: for (int i = 0; i < NCH; i++) if (hit[i]) begin m_live[i] = m_stage[i]; m_pd[i] = 1'b0; end
            4'h2: begin
                for (int i = 0; i < NCH; i++) if (hit[i]) m_stage[i] = w;
                for (int i = 0; i < NCH; i++) m_live[i] = m_stage[i];
                m_pd = '0;
            end
            4'h3: for (int i = 0; i < NCH; i++) if (hit[i]) begin
                m_stage[i] = w; m_live[i] = w; m_pd[i] = 1'b0;
            end
            4'h4: m_pd = m_pd | hit;
            4'h5: begin m_pd = '1; m_ref = 1'b0; end
            4'h6: m_ref = 1'b1;
            4'h7: m_ref = 1'b0;
            default: ;
        endcase
    endfunction

    task automatic push_expected(string tag);
        exp_t e;
        for (int i = 0; i < NCH; i++) e.code[i*RES +: RES] = m_live[i];
        e.pd = m_pd;
        e.ref_en = m_ref;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_reset(bit mid, string tag);
        @(negedge clk);
        reset_mid = mid;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        model_reset(mid);
        push_expected(tag);
    endtask

    task automatic send(logic [3:0] op, logic [3:0] sel, logic [15:0] data, int nbits, string tag);
        logic [23:0] word;
        word = {op, sel, data};
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 24) ? word[23-i] : 1'b0;
            repeat (2) @(negedge clk);
            spi_sck = 1'b1;
            repeat (2) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (2) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
        if (nbits == 24) model_apply(op, sel, data);
        push_expected(tag);
    endtask

    // Monitor: pop expected items and compare with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (dac_code_o !== e.code || pd_o !== e.pd || ref_en_o !== e.ref_en) begin
                    n_fail++;
                    $display("FAIL %s: got code=%h pd=%b ref=%b, expected code=%h pd=%b ref=%b",
                             e.tag, dac_code_o, pd_o, ref_en_o, e.code, e.pd, e.ref_en);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0, "R11 zero-scale reset");
        send(4'h0, 4'h0, 16'hABC5, 24, "R4 load A leaves live unchanged");
        send(4'h1, 4'h0, 16'h0000, 24, "R5/R12 commit A, low nibble dropped");
        send(4'h4, 4'h1, 16'h0000, 24, "R8 sleep B");
        send(4'h3, 4'h1, 16'h1230, 24, "R7 load-commit B wakes it");
        send(4'h3, 4'h2, 16'h9A5F, 24, "R1 MSB-first frame to C");
        send(4'h4, 4'hF, 16'h0000, 24, "R3/R8 sleep all via selector 15");
        send(4'h1, 4'h2, 16'h0000, 24, "R5 commit C wakes only C");
        send(4'h0, 4'h3, 16'h7770, 24, "R4 load D");
        send(4'h2, 4'h0, 16'h5550, 24, "R6 load A then commit all");
        send(4'h5, 4'h0, 16'h0000, 24, "R8 chip sleep drops reference");
        send(4'h6, 4'h0, 16'h0000, 24, "R9 reference on");
        send(4'h7, 4'h0, 16'h0000, 24, "R9 reference off");
        send(4'h6, 4'h0, 16'h0000, 24, "R9 reference on again");
        send(4'hF, 4'h0, 16'hFFFF, 24, "R10 idle operation");
        send(4'h8, 4'h0, 16'hFFFF, 24, "R10 unknown operation");
        send(4'h3, 4'h4, 16'hFFFF, 24, "R10 unknown selector");
        send(4'h7, 4'h5, 16'h0000, 24, "R10 bad selector voids chip-wide op");
        send(4'h3, 4'h0, 16'h4440, 23, "R2 23-bit frame discarded");
        send(4'h3, 4'h0, 16'h4440, 25, "R2 25-bit frame discarded");
        send(4'h3, 4'hF, 16'hFFFF, 24, "R3/R7 broadcast load-commit");
        do_reset(1'b1, "R11 mid-scale reset");
        send(4'h1, 4'h3, 16'h0000, 24, "R11 staging holds mid-scale after reset");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule